// File: doc/BRIEF.md
# Slot-Table Bus Arbiter

This block shares one memory port among up to eight bus masters. Bandwidth is split by a programmable round of sixteen time slots. Each slot names a master and carries an enable flag. A master that owns more slots gets a proportionally larger share. A common setup gives the processor every other slot so that it receives half of the port.

The arbiter keeps a slot pointer. At each arbitration it searches forward from the pointer, wrapping past the last slot, for the first enabled slot whose master is requesting. It grants that master and moves the pointer to the slot after the winner. The grant stays in place until the granted master signals that its transfer is complete. In the cycle where completion is signalled, the next winner is granted at the same clock edge, so transfers can follow each other with no gap. When no enabled slot has a requesting master, no grant is given and the pointer is left where it was.

The table is loaded through a plain word-wide write port. Four 32-bit words hold four slot bytes each. Request and completion are level control pins. The grant is a registered one-hot vector together with its binary index and a busy flag. There is no valid/ready stream at this block's edge, so no back-pressure rules apply.

Top module: `slot_arbiter`

## Requirements
- R1: After reset no grant is active, the pointer is at slot 0 and all sixteen slots are disabled, so requests alone produce no grant until the table is written.
- R2: A write with `cfg_we` high and word address `cfg_addr`=w loads slot 4w+k from byte k of `cfg_wdata` (bits 8k+7..8k). In that byte, bit 7 is the enable and bits 2..0 are the master index. Bits 6..3 are ignored.
- R3: `grant` is zero or one-hot. When `grant_busy` is high, bit `grant_idx` of `grant` is the only bit set. When `grant_busy` is low, `grant` is zero.
- R4: An arbitration picks the first slot, searching from the pointer upward and wrapping from 15 to 0, that is enabled and whose master's `req` bit is high. It grants that slot's master.
- R5: After a grant from slot s, the pointer becomes s+1, and wraps to 0 after slot 15.
- R6: While a grant is held and `xfer_done` is low, the grant and its index do not change, whatever `req` does.
- R7: If no enabled slot has a requesting master, no grant is issued and the pointer keeps its value.
- R8: In a cycle with an active grant and `xfer_done` high, the next grant (or idle, per R7) takes effect at the same clock edge. No idle cycle is inserted.
- R9: With all masters requesting and completing every cycle, each master receives grants in proportion to the number of enabled slots it owns (8 of 16 slots gives half of all grants).
- R10: `xfer_done` while no grant is active has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 8 | Per-master request lines |
| xfer_done | input | 1 | Current granted transfer completes this cycle |
| cfg_we | input | 1 | Slot table word write enable |
| cfg_addr | input | 2 | Slot table word select |
| cfg_wdata | input | 32 | Slot table word data, four slot bytes |
| grant | output | 8 | One-hot grant |
| grant_idx | output | 3 | Index of the granted master |
| grant_busy | output | 1 | A grant is active |

## Verification
The hardest case to reach is the search wrapping from slot 15 back to slot 0 across a run of disabled slots, with the pointer left unchanged by idle cycles in between. A sparse table with only the two edge slots enabled is loaded, and requests are toggled on and off between grants so that the pointer must survive idle periods. Around that, every 256-value request pattern is swept against a half-processor table. A long pseudo-random run of requests and completions is compared cycle by cycle with an arithmetic model of the pointer and search held in the bench.

// File: rtl/slot_arb_pkg.sv
package slot_arb_pkg;
  parameter int unsigned MASTERS   = 8;
  parameter int unsigned SLOTS     = 16;
  parameter int unsigned FIELD_W   = 8;
  parameter int unsigned WORD_W    = 32;
  parameter int unsigned EN_BIT    = 7;

  localparam int unsigned PER_WORD = WORD_W / FIELD_W;
  localparam int unsigned WORDS    = SLOTS / PER_WORD;
  localparam int unsigned MID_W    = $clog2(MASTERS);
  localparam int unsigned PTR_W    = $clog2(SLOTS);
  localparam int unsigned WADDR_W  = $clog2(WORDS);

  typedef logic [MID_W-1:0] mid_t;
  typedef logic [PTR_W-1:0] ptr_t;

  typedef struct packed {
    logic found;
    ptr_t slot;
    mid_t master;
  } hit_t;
endpackage

// File: rtl/slot_arb_table.sv
module slot_arb_table
  import slot_arb_pkg::*;
#(
  parameter int unsigned N_SLOTS = SLOTS,
  parameter int unsigned W_W     = WORD_W,
  parameter int unsigned F_W     = FIELD_W,
  parameter int unsigned M_W     = MID_W,
  parameter int unsigned A_W     = WADDR_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [A_W-1:0]         wr_addr,
  input  logic [W_W-1:0]         wr_data,
  output logic [N_SLOTS-1:0]     slot_en,
  output logic [N_SLOTS*M_W-1:0] slot_mid
);
  localparam int unsigned PW = W_W / F_W;

  for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
    localparam int unsigned WI = s / PW;
    localparam int unsigned BI = s % PW;
    logic           en_q;
    logic [M_W-1:0] mid_q;
    logic           hit;

    assign hit = wr_en && (wr_addr == A_W'(WI));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        en_q  <= 1'b0;
        mid_q <= '0;
      end else if (hit) begin
        en_q  <= wr_data[BI*F_W + EN_BIT];
        mid_q <= wr_data[BI*F_W +: M_W];
      end
    end

    assign slot_en[s]              = en_q;
    assign slot_mid[s*M_W +: M_W]  = mid_q;
  end
endmodule

// File: rtl/slot_arb_search.sv
module slot_arb_search
  import slot_arb_pkg::*;
#(
  parameter int unsigned N_SLOTS = SLOTS,
  parameter int unsigned N_MST   = MASTERS,
  parameter int unsigned M_W     = MID_W,
  parameter int unsigned P_W     = PTR_W
) (
  input  logic [N_SLOTS-1:0]     slot_en,
  input  logic [N_SLOTS*M_W-1:0] slot_mid,
  input  logic [N_MST-1:0]       req,
  input  logic [P_W-1:0]         ptr,
  output logic                   found,
  output logic [P_W-1:0]         win_slot,
  output logic [M_W-1:0]         win_mid
);
  logic [N_SLOTS-1:0] elig;

  for (genvar s = 0; s < N_SLOTS; s++) begin : g_elig
    logic [M_W-1:0] m;
    assign m       = slot_mid[s*M_W +: M_W];
    assign elig[s] = slot_en[s] && req[m];
  end

  // Rotate eligibility so that index 0 is the pointer's slot, then take the
  // lowest set bit; lowest offset wins because it is assigned last.
  always_comb begin
    found    = 1'b0;
    win_slot = '0;
    win_mid  = '0;
    for (int off = N_SLOTS - 1; off >= 0; off--) begin
      int unsigned idx;
      idx = int'(ptr) + off;
      if (idx >= N_SLOTS) idx = idx - N_SLOTS;
      if (elig[idx]) begin
        found    = 1'b1;
        win_slot = P_W'(idx);
        win_mid  = slot_mid[idx*M_W +: M_W];
      end
    end
  end
endmodule

// File: rtl/slot_arb_grant.sv
module slot_arb_grant
  import slot_arb_pkg::*;
#(
  parameter int unsigned N_SLOTS = SLOTS,
  parameter int unsigned N_MST   = MASTERS,
  parameter int unsigned M_W     = MID_W,
  parameter int unsigned P_W     = PTR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xfer_done,
  input  logic             found,
  input  logic [P_W-1:0]   win_slot,
  input  logic [M_W-1:0]   win_mid,
  output logic [P_W-1:0]   ptr,
  output logic             busy,
  output logic [M_W-1:0]   owner,
  output logic [N_MST-1:0] grant
);
  logic           rearb;
  logic [P_W-1:0] ptr_after;

  assign rearb     = !busy || xfer_done;
  assign ptr_after = (win_slot == P_W'(N_SLOTS - 1)) ? '0 : win_slot + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      owner <= '0;
      ptr   <= '0;
    end else if (rearb) begin
      busy <= found;
      if (found) begin
        owner <= win_mid;
        ptr   <= ptr_after;
      end
    end
  end

  for (genvar m = 0; m < N_MST; m++) begin : g_onehot
    assign grant[m] = busy && (owner == M_W'(m));
  end
endmodule

// File: rtl/slot_arbiter.sv
module slot_arbiter
  import slot_arb_pkg::*;
#(
  parameter int unsigned N_MST   = MASTERS,
  parameter int unsigned N_SLOTS = SLOTS,
  parameter int unsigned W_W     = WORD_W,
  parameter int unsigned F_W     = FIELD_W
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [N_MST-1:0]              req,
  input  logic                          xfer_done,
  input  logic                          cfg_we,
  input  logic [$clog2(N_SLOTS/(W_W/F_W))-1:0] cfg_addr,
  input  logic [W_W-1:0]                cfg_wdata,
  output logic [N_MST-1:0]              grant,
  output logic [$clog2(N_MST)-1:0]      grant_idx,
  output logic                          grant_busy
);
  localparam int unsigned L_MW = $clog2(N_MST);
  localparam int unsigned L_PW = $clog2(N_SLOTS);
  localparam int unsigned L_AW = $clog2(N_SLOTS/(W_W/F_W));

  logic [N_SLOTS-1:0]      slot_en;
  logic [N_SLOTS*L_MW-1:0] slot_mid;
  logic [L_PW-1:0]         ptr;
  logic                    found;
  logic [L_PW-1:0]         win_slot;
  logic [L_MW-1:0]         win_mid;

  slot_arb_table #(
    .N_SLOTS(N_SLOTS), .W_W(W_W), .F_W(F_W), .M_W(L_MW), .A_W(L_AW)
  ) u_table (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_addr(cfg_addr),
    .wr_data(cfg_wdata), .slot_en(slot_en), .slot_mid(slot_mid)
  );

  slot_arb_search #(
    .N_SLOTS(N_SLOTS), .N_MST(N_MST), .M_W(L_MW), .P_W(L_PW)
  ) u_search (
    .slot_en(slot_en), .slot_mid(slot_mid), .req(req), .ptr(ptr),
    .found(found), .win_slot(win_slot), .win_mid(win_mid)
  );

  slot_arb_grant #(
    .N_SLOTS(N_SLOTS), .N_MST(N_MST), .M_W(L_MW), .P_W(L_PW)
  ) u_grant (
    .clk(clk), .rst_n(rst_n), .xfer_done(xfer_done), .found(found),
    .win_slot(win_slot), .win_mid(win_mid), .ptr(ptr),
    .busy(grant_busy), .owner(grant_idx), .grant(grant)
  );
endmodule

// File: rtl/slot_arbiter_checker.sv
module slot_arbiter_checker #(
  parameter int unsigned N_MST = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [N_MST-1:0]         req,
  input logic                     xfer_done,
  input logic [N_MST-1:0]         grant,
  input logic [$clog2(N_MST)-1:0] grant_idx,
  input logic                     grant_busy
);
  p_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  p_busy_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
    grant_busy == (grant != '0));

  p_idx_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
    grant_busy |-> grant[grant_idx]);

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_busy && !xfer_done) |=> (grant_busy && $stable(grant_idx)));

  p_req_before_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_busy) |-> ((($past(req) >> grant_idx) & 1) != 0));

  p_idle_stays_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!grant_busy && req == '0) |=> !grant_busy);
endmodule

bind slot_arbiter slot_arbiter_checker #(.N_MST(N_MST)) u_checker (
  .clk(clk), .rst_n(rst_n), .req(req), .xfer_done(xfer_done),
  .grant(grant), .grant_idx(grant_idx), .grant_busy(grant_busy)
);

// File: tb/test_slot_arbiter.sv
`timescale 1ns/1ps
module test_slot_arbiter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  req = '0;
  logic        xfer_done = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [7:0]  grant;
  logic [2:0]  grant_idx;
  logic        grant_busy;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  // bench model
  bit       m_en [16];
  int       m_mid [16];
  int       m_ptr;
  bit       m_busy;
  int       m_own;

  always #2 clk = ~clk;

  slot_arbiter i_slot_arbiter (
    .clk(clk), .rst_n(rst_n), .req(req), .xfer_done(xfer_done),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .grant(grant), .grant_idx(grant_idx), .grant_busy(grant_busy)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic write_word(input int w, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 2'(w); cfg_wdata = d;
    req = '0; xfer_done = 1'b0;
    @(negedge clk);
    cfg_we = 1'b0;
    for (int k = 0; k < 4; k++) begin
      m_en[w*4+k]  = d[k*8+7];
      m_mid[w*4+k] = int'(d[k*8 +: 3]);
    end
  endtask

  function automatic void model_step(input logic [7:0] r, input logic d);
    if (!m_busy || d) begin
      bit hit = 0;
      for (int off = 0; off < 16; off++) begin
        int s = (m_ptr + off) % 16;
        if (!hit && m_en[s] && r[m_mid[s]]) begin
          hit = 1; m_own = m_mid[s]; m_ptr = (s + 1) % 16;
        end
      end
      m_busy = hit;
    end
  endfunction

  // Drive at negedge, clock once, compare just before the next negedge.
  task automatic step(input string tag, input logic [7:0] r, input logic d);
    logic [7:0] eg;
    @(negedge clk);
    req = r; xfer_done = d;
    model_step(r, d);
    @(posedge clk); #1;
    eg = m_busy ? (8'd1 << m_own) : 8'd0;
    check({tag, " grant"}, 32'(grant), 32'(eg));
    check({tag, " busy"}, 32'(grant_busy), 32'(m_busy));
    if (m_busy) check({tag, " idx"}, 32'(grant_idx), 32'(m_own));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; req = '0; xfer_done = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    for (int s = 0; s < 16; s++) begin m_en[s] = 0; m_mid[s] = 0; end
    m_ptr = 0; m_busy = 0; m_own = 0;
  endtask

  // Half-processor table: even slots master 0, odd slots masters 1..7,1.
  // Bits 6..3 carry junk that must be ignored (R2).
  task automatic load_half();
    for (int w = 0; w < 4; w++) begin
      logic [31:0] d;
      for (int k = 0; k < 4; k++) begin
        int s = w*4 + k;
        int m = (s % 2 == 0) ? 0 : ((s / 2) % 7) + 1;
        d[k*8 +: 8] = 8'h80 | 8'(m) | 8'h78;
      end
      write_word(w, d);
    end
  endtask

  initial begin
    int cnt0;
    int cnt1;
    logic [15:0] lfsr;
    do_reset();

    // R1: reset state and disabled table
    #1;
    check("R1 reset grant", 32'(grant), 0);
    check("R1 reset busy", 32'(grant_busy), 0);
    for (int i = 0; i < 4; i++) step("R1 disabled table", 8'hff, 1'b1);

    // R2/R4/R3: sweep every request pattern on the half table
    load_half();
    for (int r = 0; r < 256; r++) begin
      step("R4 sweep", 8'(r), 1'b1);
      step("R2 sweep", 8'(r), 1'b1);
      step("R3 sweep", 8'(r), 1'b1);
    end

    // R9: proportional share over two full rounds
    do_reset();
    load_half();
    cnt0 = 0; cnt1 = 0;
    for (int i = 0; i < 32; i++) begin
      step("R9 share", 8'hff, 1'b1);
      if (grant_busy && grant_idx == 3'd0) cnt0++;
      if (grant_busy && grant_idx == 3'd1) cnt1++;
    end
    check("R9 master0 grants", 32'(cnt0), 16);
    check("R9 master1 grants", 32'(cnt1), 4);

    // R6: grant held while transfer incomplete, requests dropped
    step("R6 start", 8'h04, 1'b1);
    for (int i = 0; i < 5; i++) step("R6 hold", 8'(i * 37), 1'b0);
    step("R8 release", 8'h00, 1'b1);

    // R10 / R7: idle with completion pulses, pointer kept
    for (int i = 0; i < 4; i++) step("R10 idle done", 8'h00, 1'b1);
    step("R7 resume from pointer", 8'hfe, 1'b0);
    step("R8 back-to-back", 8'hfe, 1'b1);

    // R5: wrap from slot 15 to slot 0 across disabled slots
    do_reset();
    write_word(0, 32'h0000_0082);
    write_word(3, 32'h8600_0000);
    step("R5 first", 8'h44, 1'b1);
    check("R5 slot0 first", 32'(grant_idx), 2);
    step("R5 to 15", 8'h44, 1'b1);
    check("R5 slot15 next", 32'(grant_idx), 6);
    step("R5 wrap", 8'h44, 1'b1);
    check("R5 wrapped to 0", 32'(grant_idx), 2);
    step("R7 idle", 8'h00, 1'b1);
    step("R7 idle", 8'h01, 1'b1);
    step("R7 pointer kept", 8'h44, 1'b1);
    check("R7 resumes at 15", 32'(grant_idx), 6);

    // R8/R4: long pseudo-random run on a mixed table
    do_reset();
    write_word(0, 32'h8380_0581);
    write_word(1, 32'h0784_8086);
    write_word(2, 32'h8082_0087);
    write_word(3, 32'h8185_8380);
    lfsr = 16'hace1;
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step("R8 random", lfsr[7:0], lfsr[9] | lfsr[11]);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule